// File: doc/BRIEF.md
# Banked Level-Sensitive Interrupt Controller

This block gathers 96 level-sensitive interrupt requests, arranged as three banks of 32 lines. It resolves them onto two processor-facing outputs: a normal interrupt channel and a fast interrupt channel. Each line has a 6-bit priority and a route bit that steers it to one of the two channels. Each bank has a mask, with a plain write, a clear-only write and a set-only write. Each bank also has software-raised interrupt bits, with a set write and a clear write. Two read-only views show, per channel, which lines are both pending and unmasked.

Each channel holds a decision until software re-arms it. While a channel is armed, and no global mask blocks it, an eligible line makes the channel assert its output and latch a code. The code is the number of the winning line. Software reads the code with no side effect, services the source, and then re-arms the channel through the control register. The register port is a simple synchronous word bus. Read data returns one cycle after the address is presented.

Top module: `banked_level_intc`

## Requirements
- R1: After reset, every bank mask reads 0xFFFFFFFF. Pending, software bits, route bits and priorities are 0. Both outputs are low, both codes read 0, the global mask is off and both channels are armed.
- R2: Raw status (bank base + 0x00, where bank base = 0x80 + 0x20*bank) shows the request levels sampled at the previous clock edge. A line becomes pending when its request is high and its previous sample was low.
- R3: When any request of a bank goes from high to low, that bank's whole pending word becomes its new raw levels OR its software bits.
- R4: Mask (base + 0x04) is written whole. A write to base + 0x08 clears the set bits and a write to base + 0x0C sets them. Both of these aliases read 0. A mask bit of 1 blocks the line.
- R5: A write to base + 0x10 ORs the data into the software bits and into pending; reading base + 0x10 returns the software bits. A write to base + 0x14 clears the set bits in the software bits and then loads pending with software bits AND raw levels. Base + 0x14 reads 0.
- R6: Base + 0x18 reads pending AND NOT mask AND NOT route. Base + 0x1C reads pending AND NOT mask AND route.
- R7: The configuration of line n is at 0x100 + 4*n. Bits [7:2] hold the priority and bit 0 the route (1 = fast channel). Bit 1 reads 0.
- R8: An armed channel whose global mask is off and that has at least one eligible line asserts its output one edge later. It latches the code of the eligible line with the numerically lowest priority; among equal priorities the highest line number wins. It then disarms and holds output and code.
- R9: Writing 1 to control (0x48) bit 0 drops the normal output and re-arms that channel. Bit 1 does the same for the fast channel. Reading the codes at 0x40 (normal) and 0x44 (fast) changes nothing.
- R10: Control bit 2 sets the global mask, which blocks every new decision. It reads back in bit 2.
- R11: 0x00 reads 0x21, 0x14 reads 1, and the protection register at 0x4C reads 0 and ignores writes.
- R12: At 0x10, bit 0 is a read/write autoidle flag. Writing 1 to bit 1 returns the whole block to its reset state. 0x50 holds a 2-bit read/write field.
- R13: Writes to read-only offsets, to unmapped offsets and to bank index 3 have no effect. Such offsets read 0.
- R14: Read data shows the register addressed at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 96 | Level interrupt requests, line n on bit n |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 12 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The assertions check the following on every cycle:
- once a channel output rises, it stays high until a re-arm or a soft reset;
- a re-arm drops the output on the next edge;
- a rising output always points at a line that was eligible on that channel;
- no decision happens while the global mask is on;
- the fixed identification and status reads return their constants.

Only the bench scenarios can show the rest:
- the tie rule and the lowest-value-wins rule;
- the whole-bank pending rewrite on a falling request;
- the software clear that ANDs with raw levels;
- the alias writes, and that accesses to the absent fourth bank are dropped;
- the soft reset.

The bench checks these against a reference model while the request lines toggle randomly.

// File: rtl/intc_pkg.sv
package intc_pkg;

  localparam int BANK_LINES = 32;

  // global register offsets
  localparam int OFF_REV  = 12'h000;
  localparam int OFF_CFG  = 12'h010;
  localparam int OFF_STAT = 12'h014;
  localparam int OFF_CIRQ = 12'h040;
  localparam int OFF_CFIQ = 12'h044;
  localparam int OFF_CTRL = 12'h048;
  localparam int OFF_PROT = 12'h04C;
  localparam int OFF_IDLE = 12'h050;
  localparam int OFF_LINE = 12'h100;

  // word index inside one bank window
  typedef enum logic [2:0] {
    BR_RAW      = 3'd0,
    BR_MASK     = 3'd1,
    BR_MASK_CLR = 3'd2,
    BR_MASK_SET = 3'd3,
    BR_SW_SET   = 3'd4,
    BR_SW_CLR   = 3'd5,
    BR_PEND_IRQ = 3'd6,
    BR_PEND_FIQ = 3'd7
  } bank_reg_e;

endpackage

// File: rtl/intc_bank.sv
module intc_bank
  import intc_pkg::*;
#(
  parameter int W = BANK_LINES
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         soft_clr,
  input  logic [W-1:0] src,
  input  logic         wr_en,
  input  bank_reg_e    wr_sel,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] raw_q,
  output logic [W-1:0] pend_q,
  output logic [W-1:0] mask_q,
  output logic [W-1:0] swi_q
);

  logic [W-1:0] rise, fall;
  logic [W-1:0] pend_n, mask_n, swi_n;

  always_comb begin
    rise   = src & ~raw_q;
    fall   = raw_q & ~src;
    // a falling request rebuilds the bank's pending word
    pend_n = (|fall) ? (src | swi_q) : (pend_q | rise);
    mask_n = mask_q;
    swi_n  = swi_q;
    if (wr_en) begin
      case (wr_sel)
        BR_MASK:     mask_n = wdata;
        BR_MASK_CLR: mask_n = mask_q & ~wdata;
        BR_MASK_SET: mask_n = mask_q | wdata;
        BR_SW_SET: begin
          swi_n  = swi_q | wdata;
          pend_n = pend_n | swi_n;
        end
        BR_SW_CLR: begin
          swi_n  = swi_q & ~wdata;
          pend_n = swi_n & src;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || soft_clr) begin
      raw_q  <= '0;
      pend_q <= '0;
      mask_q <= '1;
      swi_q  <= '0;
    end else begin
      raw_q  <= src;
      pend_q <= pend_n;
      mask_q <= mask_n;
      swi_q  <= swi_n;
    end
  end

endmodule

// File: rtl/intc_linecfg.sv
module intc_linecfg #(
  parameter int N  = 96,
  parameter int PW = 6,
  parameter int CW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          soft_clr,
  input  logic          cfg_we,
  input  logic [CW-1:0] cfg_idx,
  input  logic [PW-1:0] cfg_prio,
  input  logic          cfg_route,
  output logic [N*PW-1:0] prio_flat,
  output logic [N-1:0]  route_v
);

  logic [PW-1:0] prio_q [N];

  always_ff @(posedge clk) begin
    if (rst || soft_clr) begin
      for (int i = 0; i < N; i++) prio_q[i] <= '0;
      route_v <= '0;
    end else if (cfg_we) begin
      prio_q[cfg_idx]  <= cfg_prio;
      route_v[cfg_idx] <= cfg_route;
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++) prio_flat[i*PW +: PW] = prio_q[i];
  end

endmodule

// File: rtl/intc_resolve.sv
module intc_resolve #(
  parameter int N  = 96,
  parameter int PW = 6,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]    elig,
  input  logic [N*PW-1:0] prio_flat,
  output logic            any_o,
  output logic [IW-1:0]   idx_o
);

  localparam int NP    = 1 << $clog2(N);
  localparam int NODES = 2 * NP - 1;

  logic          nv [NODES];
  logic [PW-1:0] np_ [NODES];
  logic [IW-1:0] ni [NODES];

  // heap-ordered compare tree: left child covers lower line numbers
  always_comb begin
    for (int i = 0; i < NP; i++) begin
      if (i < N) begin
        nv[NP-1+i]  = elig[i];
        np_[NP-1+i] = prio_flat[i*PW +: PW];
      end else begin
        nv[NP-1+i]  = 1'b0;
        np_[NP-1+i] = '0;
      end
      ni[NP-1+i] = IW'(i);
    end
    for (int k = NP - 2; k >= 0; k--) begin
      if (nv[2*k+2] && (!nv[2*k+1] || (np_[2*k+2] <= np_[2*k+1]))) begin
        nv[k]  = 1'b1;
        np_[k] = np_[2*k+2];
        ni[k]  = ni[2*k+2];
      end else begin
        nv[k]  = nv[2*k+1];
        np_[k] = np_[2*k+1];
        ni[k]  = ni[2*k+1];
      end
    end
    any_o = nv[0];
    idx_o = ni[0];
  end

endmodule

// File: rtl/intc_channel.sv
module intc_channel #(
  parameter int N  = 96,
  parameter int PW = 6,
  parameter int CW = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            soft_clr,
  input  logic [N-1:0]    elig,
  input  logic [N*PW-1:0] prio_flat,
  input  logic            gmask,
  input  logic            rearm,
  output logic            req_o,
  output logic [CW-1:0]   code_o
);

  logic          any;
  logic [CW-1:0] win;
  logic          armed_q;

  intc_resolve #(.N(N), .PW(PW), .IW(CW)) u_res (
    .elig      (elig),
    .prio_flat (prio_flat),
    .any_o     (any),
    .idx_o     (win)
  );

  always_ff @(posedge clk) begin
    if (rst || soft_clr) begin
      armed_q <= 1'b1;
      req_o   <= 1'b0;
      code_o  <= '0;
    end else begin
      if (armed_q && !gmask && any) begin
        req_o   <= 1'b1;
        code_o  <= win;
        armed_q <= 1'b0;
      end
      if (rearm) begin
        req_o   <= 1'b0;
        armed_q <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/banked_level_intc.sv
module banked_level_intc
  import intc_pkg::*;
#(
  parameter int         NBANK  = 3,
  parameter int         PRIO_W = 6,
  parameter int         AW     = 12,
  parameter int         DW     = 32,
  parameter logic [7:0] REV_ID = 8'h21
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NBANK*BANK_LINES-1:0] src_i,
  input  logic                        bus_we,
  input  logic [AW-1:0]               bus_addr,
  input  logic [DW-1:0]               bus_wdata,
  output logic [DW-1:0]               bus_rdata,
  output logic                        irq_o,
  output logic                        fiq_o
);

  localparam int            NLINE      = NBANK * BANK_LINES;
  localparam int            CW         = $clog2(NLINE);
  localparam logic [AW-1:0] LINE_BASE  = AW'(OFF_LINE);
  localparam logic [AW-1:0] LINE_LIMIT = AW'(OFF_LINE + 4 * NLINE);

  // ---------------- address decode ----------------
  logic            addr_ok, bank_hit, bank_ok, line_hit;
  logic [AW-1:0]   al;
  logic [1:0]      bsel;
  bank_reg_e       breg;
  logic [CW-1:0]   line_idx;
  logic            cfg_wr, ctrl_wr, idle_wr, soft_clr;

  always_comb begin
    addr_ok  = (bus_addr[1:0] == 2'b00);
    al       = bus_addr;
    bsel     = bus_addr[6:5];
    breg     = bank_reg_e'(bus_addr[4:2]);
    bank_hit = addr_ok && (bus_addr[AW-1:7] == (AW-7)'(1));
    bank_ok  = bank_hit && (int'(bsel) < NBANK);
    line_hit = addr_ok && (al >= LINE_BASE) && (al < LINE_LIMIT);
    line_idx = CW'((al - LINE_BASE) >> 2);
    cfg_wr   = bus_we && addr_ok && (al == AW'(OFF_CFG));
    ctrl_wr  = bus_we && addr_ok && (al == AW'(OFF_CTRL));
    idle_wr  = bus_we && addr_ok && (al == AW'(OFF_IDLE));
    soft_clr = cfg_wr && bus_wdata[1];
  end

  // ---------------- per-bank state ----------------
  logic [BANK_LINES-1:0] raw_b  [NBANK];
  logic [BANK_LINES-1:0] pend_b [NBANK];
  logic [BANK_LINES-1:0] mask_b [NBANK];
  logic [BANK_LINES-1:0] swi_b  [NBANK];
  logic [NLINE-1:0]      irq_elig, fiq_elig;
  logic [NLINE*PRIO_W-1:0] prio_flat;
  logic [NLINE-1:0]      route_v;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    intc_bank #(.W(BANK_LINES)) u_bank (
      .clk      (clk),
      .rst      (rst),
      .soft_clr (soft_clr),
      .src      (src_i[b*BANK_LINES +: BANK_LINES]),
      .wr_en    (bus_we && bank_ok && (int'(bsel) == b)),
      .wr_sel   (breg),
      .wdata    (bus_wdata[BANK_LINES-1:0]),
      .raw_q    (raw_b[b]),
      .pend_q   (pend_b[b]),
      .mask_q   (mask_b[b]),
      .swi_q    (swi_b[b])
    );
    assign irq_elig[b*BANK_LINES +: BANK_LINES] =
      pend_b[b] & ~mask_b[b] & ~route_v[b*BANK_LINES +: BANK_LINES];
    assign fiq_elig[b*BANK_LINES +: BANK_LINES] =
      pend_b[b] & ~mask_b[b] & route_v[b*BANK_LINES +: BANK_LINES];
  end

  // ---------------- per-line configuration ----------------
  intc_linecfg #(.N(NLINE), .PW(PRIO_W), .CW(CW)) u_cfg (
    .clk       (clk),
    .rst       (rst),
    .soft_clr  (soft_clr),
    .cfg_we    (bus_we && line_hit),
    .cfg_idx   (line_idx),
    .cfg_prio  (bus_wdata[PRIO_W+1:2]),
    .cfg_route (bus_wdata[0]),
    .prio_flat (prio_flat),
    .route_v   (route_v)
  );

  // ---------------- global registers ----------------
  logic       gmask_q, autoidle_q;
  logic [1:0] idle_q;

  always_ff @(posedge clk) begin
    if (rst || soft_clr) begin
      gmask_q    <= 1'b0;
      autoidle_q <= 1'b0;
      idle_q     <= '0;
    end else begin
      if (ctrl_wr) gmask_q    <= bus_wdata[2];
      if (cfg_wr)  autoidle_q <= bus_wdata[0];
      if (idle_wr) idle_q     <= bus_wdata[1:0];
    end
  end

  // ---------------- two decision channels ----------------
  logic [CW-1:0] code_q [2];
  logic [1:0]    req_q;

  for (genvar c = 0; c < 2; c++) begin : g_chan
    intc_channel #(.N(NLINE), .PW(PRIO_W), .CW(CW)) u_chan (
      .clk       (clk),
      .rst       (rst),
      .soft_clr  (soft_clr),
      .elig      ((c == 0) ? irq_elig : fiq_elig),
      .prio_flat (prio_flat),
      .gmask     (gmask_q),
      .rearm     (ctrl_wr && bus_wdata[c]),
      .req_o     (req_q[c]),
      .code_o    (code_q[c])
    );
  end

  assign irq_o = req_q[0];
  assign fiq_o = req_q[1];

  // ---------------- read path ----------------
  logic [DW-1:0] rd_n;

  always_comb begin
    rd_n = '0;
    if (bank_ok) begin
      for (int b = 0; b < NBANK; b++) begin
        if (int'(bsel) == b) begin
          case (breg)
            BR_RAW:      rd_n = DW'(raw_b[b]);
            BR_MASK:     rd_n = DW'(mask_b[b]);
            BR_SW_SET:   rd_n = DW'(swi_b[b]);
            BR_PEND_IRQ: rd_n = DW'(irq_elig[b*BANK_LINES +: BANK_LINES]);
            BR_PEND_FIQ: rd_n = DW'(fiq_elig[b*BANK_LINES +: BANK_LINES]);
            default:     rd_n = '0;
          endcase
        end
      end
    end else if (line_hit) begin
      rd_n = DW'({prio_flat[line_idx*PRIO_W +: PRIO_W], 1'b0, route_v[line_idx]});
    end else if (addr_ok) begin
      case (al)
        AW'(OFF_REV):  rd_n = DW'(REV_ID);
        AW'(OFF_CFG):  rd_n = DW'(autoidle_q);
        AW'(OFF_STAT): rd_n = DW'(1);
        AW'(OFF_CIRQ): rd_n = DW'(code_q[0]);
        AW'(OFF_CFIQ): rd_n = DW'(code_q[1]);
        AW'(OFF_CTRL): rd_n = DW'({gmask_q, 2'b00});
        AW'(OFF_IDLE): rd_n = DW'(idle_q);
        default:       rd_n = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_n;
  end

endmodule

// File: rtl/banked_level_intc_chk.sv
module banked_level_intc_chk #(
  parameter int NLINE = 96,
  parameter int CW    = 7,
  parameter int AW    = 12,
  parameter int DW    = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_we,
  input logic [AW-1:0]    bus_addr,
  input logic [DW-1:0]    bus_wdata,
  input logic [DW-1:0]    bus_rdata,
  input logic             irq_o,
  input logic             fiq_o,
  input logic [CW-1:0]    irq_code,
  input logic [CW-1:0]    fiq_code,
  input logic [NLINE-1:0] irq_elig,
  input logic [NLINE-1:0] fiq_elig,
  input logic             gmask_q
);

  logic ctrl_w, soft_w;
  assign ctrl_w = bus_we && (bus_addr == AW'(12'h048));
  assign soft_w = bus_we && (bus_addr == AW'(12'h010)) && bus_wdata[1];

  // R8: a decided output holds until re-armed or soft reset
  p_irq_hold_r8: assert property (@(posedge clk) disable iff (rst)
    irq_o && !(ctrl_w && bus_wdata[0]) && !soft_w |=> irq_o);
  p_fiq_hold_r8: assert property (@(posedge clk) disable iff (rst)
    fiq_o && !(ctrl_w && bus_wdata[1]) && !soft_w |=> fiq_o);

  // R9: re-arm drops the output on the next edge
  p_irq_rearm_r9: assert property (@(posedge clk) disable iff (rst)
    ctrl_w && bus_wdata[0] |=> !irq_o);
  p_fiq_rearm_r9: assert property (@(posedge clk) disable iff (rst)
    ctrl_w && bus_wdata[1] |=> !fiq_o);

  // R8: winner was eligible on its own channel one cycle earlier
  p_irq_pick_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> ((($past(irq_elig)) >> irq_code) & NLINE'(1)) != '0);
  p_fiq_pick_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(fiq_o) |-> ((($past(fiq_elig)) >> fiq_code) & NLINE'(1)) != '0);

  // R10: global mask blocks new decisions
  p_gmask_block_r10: assert property (@(posedge clk) disable iff (rst)
    ($rose(irq_o) || $rose(fiq_o)) |-> !$past(gmask_q));

  // R11: fixed identification and status words
  p_status_r11: assert property (@(posedge clk) disable iff (rst)
    $past(bus_addr == AW'(12'h014)) && !$past(rst) |-> bus_rdata == DW'(1));
  p_revision_r11: assert property (@(posedge clk) disable iff (rst)
    $past(bus_addr == AW'(12'h000)) && !$past(rst) |-> bus_rdata == DW'(8'h21));

endmodule

bind banked_level_intc banked_level_intc_chk #(
  .NLINE(NLINE), .CW(CW), .AW(AW), .DW(DW)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .irq_o     (irq_o),
  .fiq_o     (fiq_o),
  .irq_code  (code_q[0]),
  .fiq_code  (code_q[1]),
  .irq_elig  (irq_elig),
  .fiq_elig  (fiq_elig),
  .gmask_q   (gmask_q)
);

// File: tb/banked_level_intc_test.sv
module banked_level_intc_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [95:0] src = '0;
  logic        we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wd = '0;
  logic [31:0] rd;
  logic        irq, fiq;

  always #5 clk = ~clk;

  banked_level_intc uut (
    .clk(clk), .rst(rst), .src_i(src), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wd), .bus_rdata(rd), .irq_o(irq), .fiq_o(fiq)
  );

  int n_chk = 0;
  int n_fail = 0;

  // ---------------- reference model ----------------
  logic [95:0] m_raw, m_pend, m_mask, m_swi, m_route;
  logic [5:0]  m_prio [96];
  logic [1:0]  m_armed, m_out;
  int          m_code [2];
  logic        m_gmask, m_auto;
  logic [1:0]  m_idle;

  task automatic model_reset();
    m_raw = '0; m_pend = '0; m_mask = '1; m_swi = '0; m_route = '0;
    for (int i = 0; i < 96; i++) m_prio[i] = '0;
    m_armed = 2'b11; m_out = 2'b00; m_code[0] = 0; m_code[1] = 0;
    m_gmask = 1'b0; m_auto = 1'b0; m_idle = 2'b00;
  endtask

  function automatic int pick(logic [95:0] e);
    int best = -1;
    for (int i = 0; i < 96; i++)
      if (e[i] && (best < 0 || m_prio[i] <= m_prio[best])) best = i;
    return best;
  endfunction

  function automatic logic [31:0] model_read(logic [11:0] a);
    int b;
    logic [31:0] p, m, r;
    if (a >= 12'h080 && a < 12'h100) begin
      b = int'(a[6:5]);
      if (b >= 3) return 32'h0;
      p = m_pend[b*32 +: 32]; m = m_mask[b*32 +: 32]; r = m_route[b*32 +: 32];
      case (a[4:2])
        3'd0: return m_raw[b*32 +: 32];
        3'd1: return m;
        3'd4: return m_swi[b*32 +: 32];
        3'd6: return p & ~m & ~r;
        3'd7: return p & ~m & r;
        default: return 32'h0;
      endcase
    end
    if (a >= 12'h100 && a < 12'h280) begin
      b = int'((a - 12'h100) >> 2);
      return {24'h0, m_prio[b], 1'b0, m_route[b]};
    end
    case (a)
      12'h000: return 32'h21;
      12'h010: return {31'h0, m_auto};
      12'h014: return 32'h1;
      12'h040: return 32'(m_code[0]);
      12'h044: return 32'(m_code[1]);
      12'h048: return {29'h0, m_gmask, 2'b00};
      12'h050: return {30'h0, m_idle};
      default: return 32'h0;
    endcase
  endfunction

  task automatic model_edge(logic w, logic [11:0] a, logic [31:0] d, logic [95:0] s);
    logic [95:0] el;
    logic [31:0] rise, fall, pn, raw_o, sw;
    int b, k;
    if (w && a == 12'h010 && d[1]) begin
      model_reset();
      return;
    end
    for (int c = 0; c < 2; c++) begin
      el = m_pend & ~m_mask & (c == 1 ? m_route : ~m_route);
      if (m_armed[c] && !m_gmask && el != '0) begin
        m_out[c] = 1'b1; m_code[c] = pick(el); m_armed[c] = 1'b0;
      end
    end
    if (w && a == 12'h048) begin
      m_gmask = d[2];
      for (int c = 0; c < 2; c++)
        if (d[c]) begin m_out[c] = 1'b0; m_armed[c] = 1'b1; end
    end
    if (w && a == 12'h010) m_auto = d[0];
    if (w && a == 12'h050) m_idle = d[1:0];
    for (int bb = 0; bb < 3; bb++) begin
      raw_o = m_raw[bb*32 +: 32];
      rise  = s[bb*32 +: 32] & ~raw_o;
      fall  = raw_o & ~s[bb*32 +: 32];
      pn    = (fall != 0) ? (s[bb*32 +: 32] | m_swi[bb*32 +: 32]) : (m_pend[bb*32 +: 32] | rise);
      sw    = m_swi[bb*32 +: 32];
      if (w && a >= 12'h080 && a < 12'h100 && int'(a[6:5]) == bb) begin
        case (a[4:2])
          3'd1: m_mask[bb*32 +: 32] = d;
          3'd2: m_mask[bb*32 +: 32] = m_mask[bb*32 +: 32] & ~d;
          3'd3: m_mask[bb*32 +: 32] = m_mask[bb*32 +: 32] | d;
          3'd4: begin sw = sw | d; pn = pn | sw; end
          3'd5: begin sw = sw & ~d; pn = sw & s[bb*32 +: 32]; end
          default: ;
        endcase
      end
      m_pend[bb*32 +: 32] = pn;
      m_swi[bb*32 +: 32]  = sw;
    end
    if (w && a >= 12'h100 && a < 12'h280) begin
      k = int'((a - 12'h100) >> 2);
      m_prio[k] = d[7:2]; m_route[k] = d[0];
    end
    b = 0;
    m_raw = s;
  endtask

  // ---------------- checking helpers ----------------
  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(logic [11:0] a);
    if (a >= 12'h080 && a < 12'h100) begin
      if (a[6:5] == 2'd3) return "R13 absent bank";
      case (a[4:2])
        3'd0: return "R2 raw";
        3'd1, 3'd2, 3'd3: return "R4 mask";
        3'd4, 3'd5: return "R5 software";
        default: return "R6 pending view";
      endcase
    end
    if (a >= 12'h100 && a < 12'h280) return "R7 line config";
    case (a)
      12'h040, 12'h044: return "R9 code";
      12'h048: return "R10 control";
      12'h000, 12'h014, 12'h04C: return "R11 ident";
      12'h010, 12'h050: return "R12 config";
      default: return "R13 unmapped";
    endcase
  endfunction

  task automatic step(logic w, logic [11:0] a, logic [31:0] d);
    logic [31:0] exp;
    we = w; addr = a; wd = d;
    exp = model_read(a);
    @(posedge clk);
    model_edge(w, a, d, src);
    #2;
    check(tag_of(a), rd, exp);
    check("R8 irq output", {31'h0, irq}, {31'h0, m_out[0]});
    check("R8 fiq output", {31'h0, fiq}, {31'h0, m_out[1]});
    we = 1'b0;
  endtask

  task automatic rd_expect(logic [11:0] a, logic [31:0] exp, string tag);
    step(1'b0, a, 32'h0);
    check(tag, rd, exp);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b0, 12'h000, 32'h0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  // ---------------- stimulus ----------------
  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;

    // R1 reset state
    check("R1 irq low", {31'h0, irq}, 32'h0);
    check("R1 fiq low", {31'h0, fiq}, 32'h0);
    rd_expect(12'h084, 32'hFFFF_FFFF, "R1 mask reset");
    rd_expect(12'h0C4, 32'hFFFF_FFFF, "R1 mask reset bank2");
    rd_expect(12'h044, 32'h0, "R1 fast code");
    rd_expect(12'h048, 32'h0, "R1 control");

    // R11 identification
    rd_expect(12'h000, 32'h21, "R11 revision");
    rd_expect(12'h014, 32'h1, "R11 status");
    step(1'b1, 12'h04C, 32'h1);
    rd_expect(12'h04C, 32'h0, "R11 protection");

    // R7 line configuration
    step(1'b1, 12'h114, 32'h0C);          // line 5  prio 3
    step(1'b1, 12'h1A0, 32'h0C);          // line 40 prio 3
    step(1'b1, 12'h218, 32'h05);          // line 70 prio 1 fast
    rd_expect(12'h218, 32'h05, "R7 prio+route");
    rd_expect(12'h1A0, 32'h0C, "R7 prio");

    // R4 mask aliases
    step(1'b1, 12'h088, 32'h0000_0020);
    step(1'b1, 12'h0A8, 32'h0000_0100);
    step(1'b1, 12'h0C8, 32'h0000_0040);
    rd_expect(12'h084, 32'hFFFF_FFDF, "R4 mask clear");
    rd_expect(12'h088, 32'h0, "R4 alias reads 0");

    // R2 / R8 tie toward the higher line
    src[5] = 1'b1; src[40] = 1'b1;
    idle(3);
    rd_expect(12'h080, 32'h0000_0020, "R2 raw bank0");
    rd_expect(12'h0A0, 32'h0000_0100, "R2 raw bank1");
    check("R8 irq asserted", {31'h0, irq}, 32'h1);
    rd_expect(12'h040, 32'd40, "R8 tie picks higher line");
    rd_expect(12'h040, 32'd40, "R9 code read has no side effect");
    check("R9 irq still high", {31'h0, irq}, 32'h1);

    // R6 views
    rd_expect(12'h098, 32'h0000_0020, "R6 normal view bank0");
    rd_expect(12'h0BC, 32'h0, "R6 fast view bank1");

    // fast channel
    src[70] = 1'b1;
    idle(3);
    check("R8 fiq asserted", {31'h0, fiq}, 32'h1);
    rd_expect(12'h044, 32'd70, "R8 fast code");
    rd_expect(12'h0D8, 32'h0, "R6 normal view bank2");
    rd_expect(12'h0DC, 32'h0000_0040, "R6 fast view bank2");

    // R9 re-arm, R8 lower value wins
    step(1'b1, 12'h114, 32'h0);           // line 5 prio 0
    step(1'b1, 12'h048, 32'h1);
    check("R9 rearm drops irq", {31'h0, irq}, 32'h0);
    idle(2);
    rd_expect(12'h040, 32'd5, "R8 lowest value wins");

    // R10 global mask
    step(1'b1, 12'h048, 32'h5);
    idle(3);
    check("R10 blocked", {31'h0, irq}, 32'h0);
    rd_expect(12'h048, 32'h4, "R10 readback");
    step(1'b1, 12'h048, 32'h0);
    idle(2);
    check("R10 released", {31'h0, irq}, 32'h1);

    // R5 software bits, R3 fall rebuild
    step(1'b1, 12'h090, 32'h0000_0200);
    rd_expect(12'h090, 32'h0000_0200, "R5 software set");
    step(1'b1, 12'h088, 32'h0000_0200);
    rd_expect(12'h098, 32'h0000_0220, "R5 software pending");
    src[5] = 1'b0;
    idle(2);
    rd_expect(12'h098, 32'h0000_0200, "R3 fall rebuilds pending");
    step(1'b1, 12'h094, 32'h0000_0200);
    rd_expect(12'h098, 32'h0, "R5 software clear");
    rd_expect(12'h094, 32'h0, "R5 clear reads 0");
    step(1'b1, 12'h08C, 32'h0000_0220);
    rd_expect(12'h084, 32'hFFFF_FFFF, "R4 mask set");

    // R13 ignored accesses
    step(1'b1, 12'h0E4, 32'h0);
    rd_expect(12'h0E4, 32'h0, "R13 bank3 absent");
    step(1'b1, 12'h080, 32'hFFFF);
    rd_expect(12'h080, 32'h0, "R13 raw read-only");
    step(1'b1, 12'h060, 32'h1234);
    rd_expect(12'h060, 32'h0, "R13 unmapped");

    // R14 read latency
    step(1'b0, 12'h000, 32'h0);
    addr = 12'h014;
    #1 check("R14 old data before edge", rd, 32'h21);
    @(posedge clk);
    model_edge(1'b0, 12'h014, 32'h0, src);
    #2 check("R14 new data after edge", rd, 32'h1);

    // R12 config and soft reset
    step(1'b1, 12'h010, 32'h1);
    rd_expect(12'h010, 32'h1, "R12 autoidle");
    step(1'b1, 12'h050, 32'h3);
    rd_expect(12'h050, 32'h3, "R12 idle field");
    step(1'b1, 12'h010, 32'h2);
    check("R12 soft reset irq", {31'h0, irq}, 32'h0);
    rd_expect(12'h084, 32'hFFFF_FFFF, "R12 soft reset mask");
    rd_expect(12'h050, 32'h0, "R12 soft reset idle");

    // constrained random phase against the model
    void'($urandom(32'd2024));
    for (int it = 0; it < 1500; it++) begin
      int op;
      logic [11:0] a;
      logic [31:0] d;
      if ($urandom_range(0, 2) == 0) src[$urandom_range(0, 95)] ^= 1'b1;
      op = $urandom_range(0, 9);
      d  = $urandom;
      case (op)
        0, 1, 2: begin
          a = 12'h080 + 12'($urandom_range(0, 3) * 32) + 12'($urandom_range(0, 7) * 4);
          step(1'b1, a, d);
        end
        3: step(1'b1, 12'h100 + 12'($urandom_range(0, 100) * 4), d & 32'hFF);
        4: step(1'b1, 12'h048, d & ($urandom_range(0, 3) == 0 ? 32'h7 : 32'h3));
        5: step(1'b1, 12'h050, d);
        6: step(1'b1, 12'h010, ($urandom_range(0, 40) == 0) ? 32'h2 : (d & 32'h1));
        default: begin
          a = 12'h080 + 12'($urandom_range(0, 3) * 32) + 12'($urandom_range(0, 7) * 4);
          if (op == 9) a = 12'($urandom_range(0, 40) * 4);
          step(1'b0, a, 32'h0);
        end
      endcase
    end

    finish_run();
  end

endmodule